// File: doc/BRIEF.md
# Freezable Cross-Domain Register Synchronizer

This block carries configuration writes from a fast bus clock into a slow counting clock. The bus side keeps a live copy of every register. A write goes to that copy and marks the register dirty. When no transfer is in flight and the freeze input is low, all dirty registers are copied into one shadow snapshot. A toggle request then crosses into the slow domain. On one slow edge the slow side loads every marked register from the snapshot and toggles an acknowledge back. A per-register busy bit covers the whole time from the bus write until that acknowledge has crossed back.

Software raises freeze to stage several writes, and nothing is launched while it is high. When freeze drops, every staged register is released in one transfer and lands on the same slow edge. One bit of register 0 is a fast path. It is driven straight from the bus-domain copy, so software need not wait for busy, although busy is still raised for that write.

Top module: `rsync_xfer`

## Requirements
- R1: During and right after reset, `busy` is all zero, `sreg_o` is all zero and `fast_o` is zero.
- R2: A write to register i (address i < NREG) sets `busy[i]` at the bus edge that accepts the write.
- R3: With freeze low, the field of register i in `sreg_o` (bits i*DW and up) takes the written data. When `busy[i]` falls, that field already holds the data. The fields of the other registers keep their values.
- R4: `busy[i]` stays high until the slow-domain acknowledge has come back through the bus-side synchronizer. It never falls while the acknowledge differs from the request.
- R5: While freeze is high, no new request is launched and `sreg_o` does not change for writes staged in that time. Their busy bits stay high.
- R6: Several writes to a register that is still busy overwrite the staged value, and only the last value reaches `sreg_o`.
- R7: When freeze falls, all registers staged under freeze appear in `sreg_o` on a single slow clock edge.
- R8: A write to register 0 copies data bit FAST_BIT to `fast_o` one bus cycle later, whatever the state of freeze. `busy[0]` is still raised.
- R9: A write to an address of NREG or more changes no busy bit, no `sreg_o` field and `fast_o` not at all.
- R10: A transfer that is already in flight when freeze rises still completes. Only writes made after that are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | AW | Register index |
| wr_data | input | DW | Write data |
| freeze | input | 1 | High: hold staged writes; falling: release them together |
| busy | output | NREG | Per-register transfer-pending status |
| fast_o | output | 1 | Fast-path control bit from register 0 |
| sclk | input | 1 | Slow counting clock |
| srst_n | input | 1 | Slow-domain active-low asynchronous reset |
| sreg_o | output | NREG*DW | Slow-domain register values, register i at bits i*DW and up |

## Verification
A dirty or in-flight flag that is lost shows up first in `busy`, which drops one bus cycle later while the slow field still holds the old value. A snapshot or mask that is wrong shows up as a field that is wrong or partly updated after the round trip, within a few slow cycles. A release that is not atomic appears as two or more slow edges at which `sreg_o` changes after one unfreeze. A launch that ignores freeze changes `sreg_o` within about three slow cycles while the bench still holds freeze.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
   localparam int unsigned RS_MIN_SYNC = 2;

   function automatic int unsigned rs_addr_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rsync_flop.sv
module rsync_flop #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rsync_stage.sv
module rsync_stage #(
   parameter int NREG = 3,
   parameter int DW   = 8,
   parameter int AW   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic               freeze,
   input  logic               ack_b,
   output logic               req_tog,
   output logic [NREG-1:0]    mask,
   output logic [NREG*DW-1:0] shadow,
   output logic [NREG-1:0]    busy
);
   logic [NREG*DW-1:0] live;
   logic [NREG-1:0]    dirty, inflight, hit;
   logic               hs_idle, launch, done;

   assign hs_idle = (ack_b == req_tog);
   assign launch  = !freeze && hs_idle && (inflight == '0) && (dirty != '0);
   assign done    = hs_idle && (inflight != '0);

   genvar i;
   generate
      for (i = 0; i < NREG; i++) begin : g_reg
         assign hit[i] = wr_en && (wr_addr == AW'(i));
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)      live[i*DW +: DW] <= '0;
            else if (hit[i]) live[i*DW +: DW] <= wr_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dirty    <= '0;
         inflight <= '0;
         req_tog  <= 1'b0;
         mask     <= '0;
         shadow   <= '0;
      end else begin
         dirty <= hit | (dirty & ~{NREG{launch}});
         if (launch) begin
            inflight <= dirty;
            mask     <= dirty;
            shadow   <= live;
            req_tog  <= ~req_tog;
         end else if (done) begin
            inflight <= '0;
         end
      end
   end

   assign busy = dirty | inflight;
endmodule

// File: rtl/rsync_commit.sv
module rsync_commit #(
   parameter int NREG = 3,
   parameter int DW   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_s,
   input  logic [NREG-1:0]    mask,
   input  logic [NREG*DW-1:0] shadow,
   output logic [NREG*DW-1:0] sreg,
   output logic               ack_tog,
   output logic               commit
);
   assign commit = (req_s != ack_tog);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ack_tog <= 1'b0;
      else        ack_tog <= req_s;

   genvar i;
   generate
      for (i = 0; i < NREG; i++) begin : g_load
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                sreg[i*DW +: DW] <= '0;
            else if (commit && mask[i]) sreg[i*DW +: DW] <= shadow[i*DW +: DW];
      end
   endgenerate
endmodule

// File: rtl/rsync_xfer.sv
module rsync_xfer
   import rsync_pkg::*;
#(
   parameter int NREG        = 3,
   parameter int DW          = 8,
   parameter int AW          = rs_addr_w(NREG),
   parameter int SYNC_STAGES = 2,
   parameter bit FAST_EN     = 1'b1,
   parameter int FAST_BIT    = 0
) (
   input  logic               bclk,
   input  logic               brst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic               freeze,
   output logic [NREG-1:0]    busy,
   output logic               fast_o,
   input  logic               sclk,
   input  logic               srst_n,
   output logic [NREG*DW-1:0] sreg_o
);
   initial begin : elab_chk
      assert (NREG >= 1) else $error("NREG must be at least 1");
      assert (AW >= int'(rs_addr_w(NREG))) else $error("AW too narrow for NREG");
      assert (SYNC_STAGES >= int'(RS_MIN_SYNC)) else $error("SYNC_STAGES below minimum");
      assert (FAST_BIT >= 0 && FAST_BIT < DW) else $error("FAST_BIT outside data width");
   end

   logic               req_tog, req_s, ack_tog, ack_b, commit_s;
   logic [NREG-1:0]    mask;
   logic [NREG*DW-1:0] shadow;

   rsync_stage #(.NREG(NREG), .DW(DW), .AW(AW)) u_stage (
      .clk(bclk), .rst_n(brst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .freeze(freeze), .ack_b(ack_b),
      .req_tog(req_tog), .mask(mask), .shadow(shadow), .busy(busy)
   );

   rsync_flop #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(sclk), .rst_n(srst_n), .d(req_tog), .q(req_s)
   );

   rsync_commit #(.NREG(NREG), .DW(DW)) u_commit (
      .clk(sclk), .rst_n(srst_n), .req_s(req_s), .mask(mask),
      .shadow(shadow), .sreg(sreg_o), .ack_tog(ack_tog), .commit(commit_s)
   );

   rsync_flop #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(bclk), .rst_n(brst_n), .d(ack_tog), .q(ack_b)
   );

   generate
      if (FAST_EN) begin : g_fast
         logic fast_q;
         always_ff @(posedge bclk or negedge brst_n)
            if (!brst_n)                         fast_q <= 1'b0;
            else if (wr_en && wr_addr == AW'(0)) fast_q <= wr_data[FAST_BIT];
         assign fast_o = fast_q;
      end else begin : g_nofast
         assign fast_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rsync_chk.sv
module rsync_chk #(
   parameter int NREG     = 3,
   parameter int DW       = 8,
   parameter int AW       = 2,
   parameter bit FAST_EN  = 1'b1,
   parameter int FAST_BIT = 0
) (
   input logic               bclk,
   input logic               brst_n,
   input logic               wr_en,
   input logic [AW-1:0]      wr_addr,
   input logic [DW-1:0]      wr_data,
   input logic               freeze,
   input logic [NREG-1:0]    busy,
   input logic               fast_o,
   input logic               sclk,
   input logic               srst_n,
   input logic [NREG*DW-1:0] sreg_o,
   input logic               req_tog,
   input logic               ack_b,
   input logic               commit_s
);
   localparam logic [AW:0] NREG_W = (AW+1)'(NREG);

   genvar i;
   generate
      for (i = 0; i < NREG; i++) begin : g_reg
         AST_BUSY_ON_WRITE: assert property (@(posedge bclk) disable iff (!brst_n)
            (wr_en && wr_addr == AW'(i)) |=> busy[i]); // R2
         AST_BUSY_UNTIL_ACK: assert property (@(posedge bclk) disable iff (!brst_n)
            $fell(busy[i]) |-> $past(ack_b == req_tog)); // R4
      end
      if (NREG < (1 << AW)) begin : g_bad
         AST_BAD_ADDR_IGNORED: assert property (@(posedge bclk) disable iff (!brst_n)
            (wr_en && {1'b0, wr_addr} >= NREG_W && busy == '0) |=> busy == '0); // R9
      end
      if (FAST_EN) begin : g_fast
         AST_FAST_PATH: assert property (@(posedge bclk) disable iff (!brst_n)
            (wr_en && wr_addr == AW'(0)) |=> fast_o == $past(wr_data[FAST_BIT])); // R8
      end
   endgenerate

   AST_FREEZE_NO_LAUNCH: assert property (@(posedge bclk) disable iff (!brst_n)
      freeze |=> $stable(req_tog)); // R5

   AST_ONE_IN_FLIGHT: assert property (@(posedge bclk) disable iff (!brst_n)
      !$stable(req_tog) |-> $past(ack_b == req_tog)); // R10

   AST_ATOMIC_COMMIT: assert property (@(posedge sclk) disable iff (!srst_n)
      !$stable(sreg_o) |-> $past(commit_s)); // R7
endmodule

bind rsync_xfer rsync_chk #(
   .NREG(NREG), .DW(DW), .AW(AW), .FAST_EN(FAST_EN), .FAST_BIT(FAST_BIT)
) u_chk (
   .bclk(bclk), .brst_n(brst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .freeze(freeze), .busy(busy), .fast_o(fast_o),
   .sclk(sclk), .srst_n(srst_n), .sreg_o(sreg_o), .req_tog(req_tog),
   .ack_b(ack_b), .commit_s(commit_s)
);

// File: tb/tb_rsync_xfer.sv
module tb_rsync_xfer;
   localparam int BCLK_PERIOD = 10;
   localparam int SCLK_PERIOD = 46;
   localparam int NREG = 3;
   localparam int DW   = 8;
   localparam int AW   = 2;

   logic bclk = 1'b0, sclk = 1'b0, brst_n = 1'b0, srst_n = 1'b0;
   logic wr_en = 1'b0, freeze = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NREG-1:0] busy;
   logic fast_o;
   logic [NREG*DW-1:0] sreg_o;

   int n_chk = 0, n_err = 0, chg_cnt = 0;
   logic [NREG*DW-1:0] mon_prev = '0;
   logic [DW-1:0] model [NREG];

   rsync_xfer #(.NREG(NREG), .DW(DW), .AW(AW)) dut (
      .bclk(bclk), .brst_n(brst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .freeze(freeze), .busy(busy), .fast_o(fast_o),
      .sclk(sclk), .srst_n(srst_n), .sreg_o(sreg_o)
   );

   always #(BCLK_PERIOD/2) bclk = ~bclk;
   always #(SCLK_PERIOD/2) sclk = ~sclk;

   // counts slow edges at which any slow-domain field changed
   always @(negedge sclk) begin
      if (sreg_o != mon_prev) chg_cnt++;
      mon_prev = sreg_o;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] fld(input int i);
      return sreg_o[i*DW +: DW];
   endfunction

   task automatic bus_write(input int a, input logic [DW-1:0] d);
      @(negedge bclk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge bclk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(input int i, input string tag);
      int k = 0;
      while (busy[i] && k < 3000) begin
         @(negedge bclk);
         k++;
      end
      chk(tag, 32'(busy[i]), 0);
   endtask

   task automatic check_all(input string tag);
      for (int j = 0; j < NREG; j++) chk(tag, 32'(fld(j)), 32'(model[j]));
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(BCLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      for (int j = 0; j < NREG; j++) model[j] = '0;
      repeat (5) @(negedge bclk);
      // R1: reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 sreg", 32'(sreg_o), 0);
      chk("R1 fast", 32'(fast_o), 0);
      brst_n = 1'b1; srst_n = 1'b1;
      repeat (3) @(negedge bclk);
      chk("R1 busy after release", 32'(busy), 0);

      // sweep: each register, several data patterns, freeze low
      for (int i = 0; i < NREG; i++) begin
         for (int p = 0; p < 5; p++) begin
            v = DW'((i * 37 + p * 91 + 13) & 8'hFF);
            bus_write(i, v);
            model[i] = v;
            chk("R2 busy raised", 32'(busy[i]), 1);
            if (i == 0) chk("R8 fast bit", 32'(fast_o), 32'(v[0]));
            repeat (4) @(negedge bclk);
            chk("R4 busy held across round trip", 32'(busy[i]), 1);
            wait_idle(i, "R3 busy clears");
            check_all("R3 field value");
         end
      end

      // R6: back-to-back overwrite, then overwrite during flight
      bus_write(1, 8'h11);
      bus_write(1, 8'h22);
      model[1] = 8'h22;
      wait_idle(1, "R6 idle");
      repeat (20) @(negedge bclk);
      chk("R6 latest after back-to-back", 32'(fld(1)), 32'h22);
      bus_write(1, 8'h33);
      repeat (3) @(negedge bclk);
      bus_write(1, 8'h44);
      model[1] = 8'h44;
      wait_idle(1, "R6 idle 2");
      repeat (20) @(negedge bclk);
      chk("R6 latest after in-flight overwrite", 32'(fld(1)), 32'h44);

      // R5 / R7: stage three registers under freeze, release together
      repeat (20) @(negedge bclk);
      @(negedge bclk);
      freeze = 1'b1;
      chg_cnt = 0;
      bus_write(0, 8'hC3);
      chk("R8 fast under freeze", 32'(fast_o), 1);
      bus_write(1, 8'h5E);
      bus_write(2, 8'h9A);
      repeat (60) @(negedge bclk);
      chk("R5 busy held", 32'(busy), 32'h7);
      check_all("R5 fields unchanged");
      chk("R5 no slow change", 32'(chg_cnt), 0);
      model[0] = 8'hC3; model[1] = 8'h5E; model[2] = 8'h9A;
      freeze = 1'b0;
      for (int j = 0; j < NREG; j++) wait_idle(j, "R7 idle");
      repeat (30) @(negedge bclk);
      check_all("R7 fields released");
      chk("R7 single commit edge", 32'(chg_cnt), 1);

      // R10: freeze raised while a transfer is in flight
      bus_write(2, 8'h6D);
      @(negedge bclk);
      freeze = 1'b1;
      bus_write(1, 8'hE7);
      repeat (80) @(negedge bclk);
      model[2] = 8'h6D;
      chk("R10 in-flight completes", 32'(fld(2)), 32'h6D);
      chk("R10 in-flight busy clear", 32'(busy[2]), 0);
      chk("R10 later write held busy", 32'(busy[1]), 1);
      chk("R10 later write held value", 32'(fld(1)), 32'(model[1]));
      freeze = 1'b0;
      model[1] = 8'hE7;
      wait_idle(1, "R10 idle");
      repeat (20) @(negedge bclk);
      check_all("R10 after release");

      // R9: out-of-range address is ignored
      bus_write(3, 8'hFE);
      chk("R9 busy", 32'(busy), 0);
      chk("R9 fast", 32'(fast_o), 32'(model[0][0]));
      repeat (40) @(negedge bclk);
      chk("R9 busy later", 32'(busy), 0);
      check_all("R9 fields");

      finish_run();
   end
endmodule